// File: doc/BRIEF.md
# Masked Event Interrupt Aggregator

This block gathers 96 single-cycle hardware event inputs into three 32-bit status words. Each status bit latches when its event input is high and stays set until software acknowledges it. Software clears a bit by writing a 1 to its position in the status word.

Three independent interrupt request lines come out of the block. Each line has its own group of three 32-bit mask words, one mask word for each status word. A line requests service when any set status bit has its bit set in that line's mask group. Line 0 is the highest-priority line, line 1 the middle one and line 2 the lowest. For each line the block also reports the number of the lowest enabled pending event, together with a valid flag. A simple register port (address, write enable, write data, read data) gives access to all status and mask words.

Top module: `evt_irq_agg`

## Requirements
- R1: Synchronous active-high reset clears every status and mask word, `rd_data`, `irq_o`, `pend_vld_o` and `pend_idx_o`.
- R2: When input `evt_i[n]` is high at a rising clock edge, status word `n/32` bit `n%32` is set from that edge onward.
- R3: A write to status byte offset 4*b (b = 0..2) clears every bit of word b where the write data holds a 1. Bits where the write data holds a 0 are left unchanged.
- R4: When an event input is high in the same cycle that a write clears its status bit, the bit stays set.
- R5: Mask word b of line g (g, b = 0..2) is read and written at byte offset 0x10 + 16*g + 4*b. A write replaces the whole word.
- R6: `irq_o[g]` is registered. It is high one cycle after a status bit is set whose mask bit in group g is also set.
- R7: A status bit whose mask bit in group g is 0 has no effect on `irq_o[g]`, `pend_vld_o[g]` or `pend_idx_o` field g.
- R8: `irq_o[g]` falls one cycle after the last enabled pending bit of line g is cleared, or is masked off by a mask write.
- R9: Bits 7g+6..7g of `pend_idx_o` hold 32*b + bit of the lowest-numbered enabled pending event of line g. `pend_vld_o[g]` equals `irq_o[g]`, and the field is 0 when `pend_vld_o[g]` is 0.
- R10: Reads at any other offset, including offsets that are not multiples of 4, return 0. Writes to such offsets change no word.
- R11: `rd_data` shows, one cycle after `addr` is presented, the addressed word as it stood before any write made in that same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_i | input | 96 | Event inputs; bit n is event n |
| addr | input | 8 | Byte address of the register access |
| wr_en | input | 1 | Write strobe for the current cycle |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_o | output | 3 | Interrupt request lines, bit 0 highest priority |
| pend_vld_o | output | 3 | Per-line flag: an enabled event is pending |
| pend_idx_o | output | 21 | Per-line lowest pending event number, 7 bits per line |

## Verification
Two functions can act on a status bit in the same cycle: event capture and the write-one-to-clear acknowledge. The bench provokes this directly by raising an event input in the cycle that writes a 1 to the same bit. It then reads the word back and expects the bit to be set. In the random phase the bench also issues clear writes and mask writes while events are being captured. Its behavioural model applies the clear before the set on every edge, and the model is compared against the read data and all three request lines on every cycle.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  // Kind of register selected by an address decode
  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_STAT = 2'd1,
    SEL_MASK = 2'd2
  } sel_e;
endpackage

// File: rtl/evt_status_bank.sv
module evt_status_bank #(
  parameter int BANK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] evt_i,
  input  logic              clr_en,
  input  logic [BANK_W-1:0] clr_data,
  output logic [BANK_W-1:0] stat_q
);
  logic [BANK_W-1:0] clr_mask;

  assign clr_mask = clr_en ? clr_data : '0;

  // The clear is applied first and the new events are ORed in afterwards, so a new event wins
  always_ff @(posedge clk) begin
    if (rst) stat_q <= '0;
    else     stat_q <= (stat_q & ~clr_mask) | evt_i;
  end
endmodule

// File: rtl/evt_mask_file.sv
module evt_mask_file #(
  parameter int BANKS  = 3,
  parameter int BANK_W = 32,
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [SEL_W-1:0]        bank_sel,
  input  logic [BANK_W-1:0]       wr_data,
  output logic [BANKS*BANK_W-1:0] mask_q
);
  for (genvar b = 0; b < BANKS; b++) begin : g_word
    always_ff @(posedge clk) begin
      if (rst)
        mask_q[b*BANK_W +: BANK_W] <= '0;
      else if (wr_en && (int'(bank_sel) == b))
        mask_q[b*BANK_W +: BANK_W] <= wr_data;
    end
  end
endmodule

// File: rtl/evt_line_encoder.sv
module evt_line_encoder #(
  parameter int N     = 96,
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     stat_i,
  input  logic [N-1:0]     mask_i,
  output logic             irq_q,
  output logic             vld_q,
  output logic [IDX_W-1:0] idx_q
);
  logic [N-1:0]     pend;
  logic             found;
  logic [IDX_W-1:0] low_idx;

  assign pend = stat_i & mask_i;

  // The scan runs downward, so the last hit it records is the lowest set bit
  always_comb begin
    found   = 1'b0;
    low_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend[i]) begin
        found   = 1'b1;
        low_idx = IDX_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q <= 1'b0;
      vld_q <= 1'b0;
      idx_q <= '0;
    end else begin
      irq_q <= |pend;
      vld_q <= found;
      idx_q <= low_idx;
    end
  end
endmodule

// File: rtl/evt_irq_agg.sv
module evt_irq_agg #(
  parameter int BANKS  = 3,
  parameter int BANK_W = 32,
  parameter int LINES  = 3,
  parameter int ADDR_W = 8,
  localparam int TOTAL = BANKS * BANK_W,
  localparam int IDX_W = $clog2(TOTAL),
  localparam int SEL_W = (BANKS > 1) ? $clog2(BANKS) : 1
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [TOTAL-1:0]       evt_i,
  input  logic [ADDR_W-1:0]      addr,
  input  logic                   wr_en,
  input  logic [BANK_W-1:0]      wr_data,
  output logic [BANK_W-1:0]      rd_data,
  output logic [LINES-1:0]       irq_o,
  output logic [LINES-1:0]       pend_vld_o,
  output logic [LINES*IDX_W-1:0] pend_idx_o
);
  import evt_irq_pkg::*;

  // Address layout: bits [1:0] must be zero, [3:2] pick the word, [ADDR_W-1:4] pick the block
  // (block 0 holds the status words, block g+1 holds the mask group of line g). BANKS <= 4.
  logic                    aligned;
  logic [1:0]              slot;
  logic [ADDR_W-5:0]       blk;
  logic                    slot_ok;
  sel_e                    sel;
  logic [LINES-1:0]        line_hit;
  logic [TOTAL-1:0]        stat_flat;
  logic [TOTAL-1:0]        mask_flat [LINES];
  logic [BANK_W-1:0]       rd_mux;

  assign aligned = (addr[1:0] == 2'b00);
  assign slot    = addr[3:2];
  assign blk     = addr[ADDR_W-1:4];
  assign slot_ok = aligned && (int'(slot) < BANKS);

  always_comb begin
    sel      = SEL_NONE;
    line_hit = '0;
    if (slot_ok) begin
      if (blk == '0) sel = SEL_STAT;
      for (int g = 0; g < LINES; g++) begin
        if (int'(blk) == g + 1) begin
          sel         = SEL_MASK;
          line_hit[g] = 1'b1;
        end
      end
    end
  end

  // Status words
  for (genvar b = 0; b < BANKS; b++) begin : g_stat
    evt_status_bank #(.BANK_W(BANK_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .evt_i    (evt_i[b*BANK_W +: BANK_W]),
      .clr_en   (wr_en && (sel == SEL_STAT) && (int'(slot) == b)),
      .clr_data (wr_data),
      .stat_q   (stat_flat[b*BANK_W +: BANK_W])
    );
  end

  // Mask groups and request encoders, one of each per line
  for (genvar g = 0; g < LINES; g++) begin : g_line
    evt_mask_file #(.BANKS(BANKS), .BANK_W(BANK_W)) u_mask (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (wr_en && line_hit[g]),
      .bank_sel (SEL_W'(slot)),
      .wr_data  (wr_data),
      .mask_q   (mask_flat[g])
    );

    evt_line_encoder #(.N(TOTAL), .IDX_W(IDX_W)) u_enc (
      .clk    (clk),
      .rst    (rst),
      .stat_i (stat_flat),
      .mask_i (mask_flat[g]),
      .irq_q  (irq_o[g]),
      .vld_q  (pend_vld_o[g]),
      .idx_q  (pend_idx_o[g*IDX_W +: IDX_W])
    );
  end

  // Read path: the register holds the value from before this cycle's write
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < BANKS; b++) begin
      if (int'(slot) == b) begin
        if (sel == SEL_STAT) rd_mux = stat_flat[b*BANK_W +: BANK_W];
        for (int g = 0; g < LINES; g++) begin
          if (line_hit[g]) rd_mux = mask_flat[g][b*BANK_W +: BANK_W];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= rd_mux;
  end
endmodule

// File: rtl/evt_irq_agg_chk.sv
module evt_irq_agg_chk #(
  parameter int BANKS  = 3,
  parameter int BANK_W = 32,
  parameter int LINES  = 3,
  parameter int ADDR_W = 8,
  localparam int TOTAL = BANKS * BANK_W,
  localparam int IDX_W = $clog2(TOTAL)
) (
  input logic                   clk,
  input logic                   rst,
  input logic [TOTAL-1:0]       evt_i,
  input logic [ADDR_W-1:0]      addr,
  input logic                   wr_en,
  input logic [BANK_W-1:0]      wr_data,
  input logic [TOTAL-1:0]       stat_flat,
  input logic [LINES-1:0]       irq_o,
  input logic [LINES-1:0]       pend_vld_o,
  input logic [LINES*IDX_W-1:0] pend_idx_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (irq_o == '0 && pend_vld_o == '0));

  // R2 R4
  evt_capture_chk: assert property (@(posedge clk) disable iff (rst)
    (evt_i != '0) |=> ((stat_flat & $past(evt_i)) == $past(evt_i)));

  // R6 R9
  irq_vld_agree_chk: assert property (@(posedge clk) disable iff (rst)
    irq_o == pend_vld_o);

  for (genvar b = 0; b < BANKS; b++) begin : g_clr
    // R3
    w1c_clear_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == ADDR_W'(4 * b) && evt_i[b*BANK_W +: BANK_W] == '0)
        |=> ((stat_flat[b*BANK_W +: BANK_W] & $past(wr_data)) == '0));
  end

  for (genvar g = 0; g < LINES; g++) begin : g_idx
    // R9
    idle_idx_zero_chk: assert property (@(posedge clk) disable iff (rst)
      !pend_vld_o[g] |-> (pend_idx_o[g*IDX_W +: IDX_W] == '0));
  end
endmodule

bind evt_irq_agg evt_irq_agg_chk #(
  .BANKS(BANKS), .BANK_W(BANK_W), .LINES(LINES), .ADDR_W(ADDR_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .evt_i      (evt_i),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .stat_flat  (stat_flat),
  .irq_o      (irq_o),
  .pend_vld_o (pend_vld_o),
  .pend_idx_o (pend_idx_o)
);

// File: tb/sim_evt_irq_agg.sv
module sim_evt_irq_agg;
  localparam int BANKS = 3, BANK_W = 32, LINES = 3, ADDR_W = 8;
  localparam int TOTAL = BANKS * BANK_W;
  localparam int IDX_W = 7;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic                   rst = 1'b1;
  logic [TOTAL-1:0]       evt_i = '0;
  logic [ADDR_W-1:0]      addr = '0;
  logic                   wr_en = 1'b0;
  logic [BANK_W-1:0]      wr_data = '0;
  logic [BANK_W-1:0]      rd_data;
  logic [LINES-1:0]       irq_o;
  logic [LINES-1:0]       pend_vld_o;
  logic [LINES*IDX_W-1:0] pend_idx_o;

  evt_irq_agg u0 (.*);

  int    n_chk = 0, n_fail = 0;
  bit    started = 0, done = 0;
  string cur_req = "R1";

  // Behavioural model
  logic [31:0] m_stat [3];
  logic [31:0] m_mask [3][3];
  logic [31:0] exp_rd;
  logic [2:0]  exp_vld;
  int          exp_idx [3];

  function automatic logic [31:0] mread(input logic [7:0] a);
    int hi = a[7:4], lo = a[3:2];
    if (a[1:0] != 0 || lo > 2) return 0;
    if (hi == 0) return m_stat[lo];
    if (hi <= 3) return m_mask[hi-1][lo];
    return 0;
  endfunction

  always @(posedge clk) begin
    started = 1;
    if (rst) begin
      for (int i = 0; i < 3; i++) begin
        m_stat[i] = 0;
        for (int j = 0; j < 3; j++) m_mask[i][j] = 0;
        exp_idx[i] = 0;
      end
      exp_rd = 0; exp_vld = 0;
    end else begin
      for (int g = 0; g < 3; g++) begin
        exp_vld[g] = 0; exp_idx[g] = 0;
        for (int n = 0; n < 96; n++)
          if (!exp_vld[g] && m_stat[n/32][n%32] && m_mask[g][n/32][n%32]) begin
            exp_vld[g] = 1; exp_idx[g] = n;
          end
      end
      exp_rd = mread(addr);
      if (wr_en && addr[1:0] == 0 && addr[3:2] != 3) begin
        if (addr[7:4] == 0) m_stat[addr[3:2]] &= ~wr_data;
        else if (addr[7:4] <= 3) m_mask[addr[7:4]-1][addr[3:2]] = wr_data;
      end
      for (int b = 0; b < 3; b++) m_stat[b] |= evt_i[b*32 +: 32];
    end
  end

  task automatic chk(input string tag, input bit ok, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model
  always @(negedge clk) if (started && !done) begin
    chk({cur_req, " rd_data"}, rd_data === exp_rd, rd_data, exp_rd);
    for (int g = 0; g < 3; g++) begin
      chk({cur_req, " irq"}, irq_o[g] === exp_vld[g], 32'(irq_o[g]), 32'(exp_vld[g]));
      chk({cur_req, " vld"}, pend_vld_o[g] === exp_vld[g], 32'(pend_vld_o[g]), 32'(exp_vld[g]));
      chk({cur_req, " idx"}, pend_idx_o[g*7 +: 7] === 7'(exp_idx[g]),
          32'(pend_idx_o[g*7 +: 7]), 32'(exp_idx[g]));
    end
  end

  task automatic tick(); @(negedge clk); endtask
  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wr_en = 1; wr_data = d; tick(); wr_en = 0;
  endtask
  task automatic pulse(input int n);
    evt_i[n] = 1; tick(); evt_i = '0;
  endtask
  task automatic expect_rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    addr = a; tick();
    chk(tag, rd_data === e, rd_data, e);
  endtask

  initial begin
    repeat (3) tick();
    rst = 0;
    // R1: reset state
    expect_rd(8'h00, 0, "R1 status reset");
    chk("R1 irq reset", irq_o === 0, 32'(irq_o), 0);
    // R5: mask words
    cur_req = "R5";
    wr(8'h10, 32'h0000_00F0);
    wr(8'h24, 32'hFFFF_0000);
    wr(8'h38, 32'h0000_0001);
    wr(8'h30, 32'h8000_0000);
    expect_rd(8'h24, 32'hFFFF_0000, "R5 mask line1 word1");
    expect_rd(8'h30, 32'h8000_0000, "R5 mask line2 word0");
    // R2 R11 R6 R9
    cur_req = "R2 R11";
    pulse(5);
    expect_rd(8'h00, 32'h20, "R2 capture event5");
    chk("R6 irq line0", irq_o[0] === 1, 32'(irq_o[0]), 1);
    chk("R9 idx line0", pend_idx_o[6:0] === 5, 32'(pend_idx_o[6:0]), 5);
    // R7: unmasked-off events give no request
    cur_req = "R7";
    pulse(1); pulse(40); tick();
    chk("R7 line1 masked", irq_o[1] === 0, 32'(irq_o[1]), 0);
    pulse(63); tick();
    chk("R6 line1 raised", irq_o[1] === 1, 32'(irq_o[1]), 1);
    chk("R9 idx line1", pend_idx_o[13:7] === 63, 32'(pend_idx_o[13:7]), 63);
    // R3 R8: acknowledge
    cur_req = "R3 R8";
    wr(8'h00, 32'h20); tick();
    chk("R8 line0 falls", irq_o[0] === 0, 32'(irq_o[0]), 0);
    expect_rd(8'h00, 32'h2, "R3 partial clear");
    // R4: set wins over clear
    cur_req = "R4";
    evt_i[6] = 1; wr(8'h00, 32'h40); evt_i = '0;
    expect_rd(8'h00, 32'h42, "R4 set beats clear");
    // R8: masking off drops the line
    cur_req = "R8";
    wr(8'h24, 0); tick();
    chk("R8 line1 masked off", irq_o[1] === 0, 32'(irq_o[1]), 0);
    // R9: lowest index wins
    cur_req = "R9";
    pulse(64); pulse(31); tick();
    chk("R9 lowest on line2", pend_idx_o[20:14] === 31, 32'(pend_idx_o[20:14]), 31);
    // R10: unmapped
    cur_req = "R10";
    wr(8'h0C, 32'hFFFF_FFFF);
    wr(8'h3C, 32'hFFFF_FFFF);
    wr(8'h11, 32'hFFFF_FFFF);
    wr(8'h40, 32'hFFFF_FFFF);
    expect_rd(8'h0C, 0, "R10 unmapped read");
    expect_rd(8'h10, 32'hF0, "R10 misaligned write ignored");
    expect_rd(8'h40, 0, "R10 beyond map");
    // Random mix
    cur_req = "R2 R3 R4 R5 R6 R8 R9 R10 R11 random";
    for (int c = 0; c < 4000; c++) begin
      for (int b = 0; b < 3; b++) evt_i[b*32 +: 32] = $urandom & $urandom & $urandom;
      addr = 8'($urandom_range(0, 63));
      if ($urandom_range(0, 3) != 0) addr[1:0] = 0;
      wr_en = ($urandom_range(0, 2) == 0);
      wr_data = $urandom;
      tick();
    end
    evt_i = '0; wr_en = 0;
    // R1: reset mid-run
    cur_req = "R1";
    rst = 1; tick(); tick(); rst = 0;
    chk("R1 irq after reset", irq_o === 0, 32'(irq_o), 0);
    expect_rd(8'h10, 0, "R1 mask after reset");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1; n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule